// File: doc/BRIEF.md
# Priority and Status Time-Multiplexer

This block drives the two outgoing arbitration pins that describe a radio packet to an external coexistence arbiter: a priority pin and a status pin. At the start of each request it takes a snapshot of the radio's packet priority, its direction (transmit or receive) and its role flag (master or slave). It then presents these on the pins until the request ends. A request sequencer supplies the request level, and its rising edge marks the start of a packet. A free-running strobe supplies one pulse per microsecond.

The block has two wiring modes. In four-wire mode, priority is driven on its own pin and the status pin carries the direction. In three-wire mode the priority pin is not used. The status pin first shows the priority for a window programmed in microseconds, then switches to the direction until the request ends. A window of zero turns the priority phase off. Each of the two fields has its own polarity inversion. The window value and the mode are captured along with the packet fields at the start of a request.

Top module: `pta_prio_status_mux`

## Requirements
- R1: While reset is asserted and after reset is released, with no request, the priority pin equals `pri_inv_i` and the status pin equals `dir_inv_i`.
- R2: In the cycle after any clock edge that samples `act_i` low, both pins sit at their idle levels: the priority pin at `pri_inv_i` and the status pin at `dir_inv_i`.
- R3: Priority, direction, role, mode and window are captured on the clock edge that first samples `act_i` high. Changes to those inputs later in the same request have no effect on the pins.
- R4: In four-wire mode (`three_wire_i`=0) the priority pin shows captured priority XOR `pri_inv_i`, and the status pin shows the direction from the cycle after activation.
- R5: The direction level is 1 XOR `dir_inv_i` for a transmit and `dir_inv_i` for a receive. The transmit code is `txrx_i`=1. A packet is reported as transmit only when `txrx_i`=1 and `master_i`=1; a slave-role packet is reported as receive.
- R6: In three-wire mode with a nonzero window, the status pin shows captured priority XOR `pri_inv_i` from the cycle after activation. In three-wire mode the priority pin stays at `pri_inv_i` throughout.
- R7: The status pin changes from priority to direction right after the clock edge that counts the window's N-th tick pulse, where N is the captured window value. After N-1 counted ticks it still shows priority.
- R8: In three-wire mode with a window of 0, the status pin shows the direction from the cycle after activation.
- R9: Every new activation restarts the tick count from zero. A tick that falls on the activation edge is not counted.
- R10: If the request ends during the priority window, both pins return to idle in the next cycle. A later request runs a full window again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_us_i | input | 1 | One-cycle pulse each microsecond |
| act_i | input | 1 | Request level from the sequencer; the rising edge starts a packet |
| pri_i | input | 1 | Packet priority (1 = high) |
| txrx_i | input | 1 | Packet direction (1 = transmit) |
| master_i | input | 1 | Packet role (1 = master) |
| three_wire_i | input | 1 | 1 = priority time-shared on status pin |
| win_us_i | input | 5 | Priority window in microsecond ticks, 0 = off |
| pri_inv_i | input | 1 | Invert priority on both pins |
| dir_inv_i | input | 1 | Invert direction encoding |
| pri_pin_o | output | 1 | Priority pin |
| stat_pin_o | output | 1 | Status pin |

## Verification
Three events can fall on the same clock edge: a counted microsecond tick, the end of the priority window, and a request edge. A tick can arrive on the very edge that restarts a request. The request can also fall on the same edge where the final tick would close the window. The bench provokes these cases directly: it re-raises the request with a tick pulse on that edge, and it drops the request in the middle of a window. Random request lengths and tick spacings then make these collisions occur many more times. Each cycle the pins are compared against a reference model built from the requirements. The model gives the restart precedence over counting, and gives request end precedence over everything else.

// File: rtl/pta_mux_pkg.sv
package pta_mux_pkg;
  localparam int unsigned WIN_W = 5;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PRI  = 2'd1,
    PH_DIR  = 2'd2
  } phase_e;

  typedef struct packed {
    logic pri;
    logic dir;
    logic three_wire;
  } pkt_t;
endpackage

// File: rtl/pm_rst_sync.sv
module pm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/pm_capture.sv
module pm_capture
  import pta_mux_pkg::*;
#(
  parameter int unsigned W = WIN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         act_i,
  input  logic         pri_i,
  input  logic         txrx_i,
  input  logic         master_i,
  input  logic         three_wire_i,
  input  logic [W-1:0] win_i,
  output logic         start_o,
  output pkt_t         pkt_o,
  output logic [W-1:0] win_o,
  output logic         mux_en_o
);
  logic         act_q;
  pkt_t         pkt_q, pkt_d;
  logic [W-1:0] win_q, win_d;
  logic         mux_q, mux_d;
  logic         cap_en;

  assign start_o = act_i & ~act_q;
  assign cap_en  = start_o;

  always_comb begin
    pkt_d.pri        = pri_i;
    pkt_d.dir        = txrx_i & master_i;
    pkt_d.three_wire = three_wire_i;
    win_d            = win_i;
    mux_d            = three_wire_i & (win_i != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      pkt_q <= '0;
      win_q <= '0;
      mux_q <= 1'b0;
    end else begin
      act_q <= act_i;
      if (cap_en) begin
        pkt_q <= pkt_d;
        win_q <= win_d;
        mux_q <= mux_d;
      end
    end
  end

  assign pkt_o    = pkt_q;
  assign win_o    = win_q;
  assign mux_en_o = mux_d;

  AST_HOLD_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && act_q) |=> ($stable(pkt_q) && $stable(win_q))); // R3
  AST_WIN_MUX_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (mux_q == (pkt_q.three_wire && (win_q != '0)))); // R8
endmodule

// File: rtl/pm_window.sv
module pm_window
  import pta_mux_pkg::*;
#(
  parameter int unsigned W = WIN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         act_i,
  input  logic         start_i,
  input  logic         mux_en_i,
  input  logic         tick_i,
  input  logic [W-1:0] win_i,
  output phase_e       phase_o
);
  phase_e       phase_q, phase_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] cnt_inc;

  assign cnt_inc = cnt_q + {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (!act_i) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
    end else if (start_i) begin
      phase_d = mux_en_i ? PH_PRI : PH_DIR;
      cnt_d   = '0;
    end else if (phase_q == PH_PRI && tick_i) begin
      cnt_d = cnt_inc;
      if (cnt_inc == win_i) phase_d = PH_DIR;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign phase_o = phase_q;

  AST_CNT_BELOW_WIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PRI) |-> (cnt_q < win_i)); // R7
  AST_NO_EARLY_SWITCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PRI && act_i && !start_i && !tick_i) |=> (phase_q == PH_PRI)); // R7
  AST_RESTART_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == '0)); // R9
  AST_DROP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> (phase_q == PH_IDLE)); // R10
endmodule

// File: rtl/pm_pins.sv
module pm_pins
  import pta_mux_pkg::*;
(
  input  phase_e phase_i,
  input  pkt_t   pkt_i,
  input  logic   pri_inv_i,
  input  logic   dir_inv_i,
  output logic   pri_pin_o,
  output logic   stat_pin_o
);
  logic pri_lvl, dir_lvl;

  assign pri_lvl = pkt_i.pri ^ pri_inv_i;
  assign dir_lvl = pkt_i.dir ^ dir_inv_i;

  always_comb begin
    pri_pin_o  = pri_inv_i;
    stat_pin_o = dir_inv_i;
    unique case (phase_i)
      PH_PRI: stat_pin_o = pri_lvl;
      PH_DIR: begin
        stat_pin_o = dir_lvl;
        if (!pkt_i.three_wire) pri_pin_o = pri_lvl;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pta_prio_status_mux.sv
module pta_prio_status_mux
  import pta_mux_pkg::*;
#(
  parameter int unsigned W = WIN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_us_i,
  input  logic         act_i,
  input  logic         pri_i,
  input  logic         txrx_i,
  input  logic         master_i,
  input  logic         three_wire_i,
  input  logic [W-1:0] win_us_i,
  input  logic         pri_inv_i,
  input  logic         dir_inv_i,
  output logic         pri_pin_o,
  output logic         stat_pin_o
);
  logic         rst_n;
  logic         start;
  logic         mux_en;
  pkt_t         pkt;
  logic [W-1:0] win;
  phase_e       phase;

  pm_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_n)
  );

  pm_capture #(.W(W)) u_cap (
    .clk_i(clk_i), .rst_ni(rst_n), .act_i(act_i), .pri_i(pri_i),
    .txrx_i(txrx_i), .master_i(master_i), .three_wire_i(three_wire_i),
    .win_i(win_us_i), .start_o(start), .pkt_o(pkt), .win_o(win),
    .mux_en_o(mux_en)
  );

  pm_window #(.W(W)) u_win (
    .clk_i(clk_i), .rst_ni(rst_n), .act_i(act_i), .start_i(start),
    .mux_en_i(mux_en), .tick_i(tick_us_i), .win_i(win), .phase_o(phase)
  );

  pm_pins u_pins (
    .phase_i(phase), .pkt_i(pkt), .pri_inv_i(pri_inv_i),
    .dir_inv_i(dir_inv_i), .pri_pin_o(pri_pin_o), .stat_pin_o(stat_pin_o)
  );

  AST_IDLE_LEVELS: assert property (@(posedge clk_i) disable iff (!rst_n)
    !act_i |=> (pri_pin_o == pri_inv_i && stat_pin_o == dir_inv_i)); // R2
  AST_3W_PRI_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start && three_wire_i) |=> (pri_pin_o == pri_inv_i)); // R6
  AST_4W_PRI_DRIVEN: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start && !three_wire_i) |=> (pri_pin_o == ($past(pri_i) ^ pri_inv_i))); // R4
endmodule

// File: tb/test_pta_prio_status_mux.sv
`timescale 1ns/1ps
module test_pta_prio_status_mux;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, act = 1'b0, pri = 1'b0, txrx = 1'b0, mst = 1'b0;
  logic tw = 1'b0, pinv = 1'b0, dinv = 1'b0;
  logic [4:0] win = 5'd10;
  logic pri_pin, stat_pin;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  bit m_actq = 0, m_pri = 0, m_dir = 0, m_tw = 0;
  int m_phase = 0, m_cnt = 0, m_win = 0;

  always #10 clk = ~clk;

  pta_prio_status_mux i_pta_prio_status_mux (
    .clk_i(clk), .rst_ni(rst_n), .tick_us_i(tick), .act_i(act), .pri_i(pri),
    .txrx_i(txrx), .master_i(mst), .three_wire_i(tw), .win_us_i(win),
    .pri_inv_i(pinv), .dir_inv_i(dinv), .pri_pin_o(pri_pin), .stat_pin_o(stat_pin)
  );

  function automatic bit exp_pri();
    if (m_phase == 2 && !m_tw) return m_pri ^ pinv;
    return pinv;
  endfunction

  function automatic bit exp_stat();
    if (m_phase == 1) return m_pri ^ pinv;
    if (m_phase == 2) return m_dir ^ dinv;
    return dinv;
  endfunction

  task automatic model_step();
    bit start;
    start = act && !m_actq;
    if (!act) begin
      m_phase = 0; m_cnt = 0;
    end else if (start) begin
      m_pri = pri; m_dir = txrx && mst; m_tw = tw; m_win = int'(win);
      m_phase = (tw && win != 0) ? 1 : 2; m_cnt = 0;
    end else if (m_phase == 1 && tick) begin
      m_cnt++;
      if (m_cnt == m_win) m_phase = 2;
    end
    m_actq = act;
  endtask

  task automatic check(input string tag);
    bit ep, es;
    ep = exp_pri(); es = exp_stat();
    checks++;
    if (pri_pin !== ep || stat_pin !== es) begin
      fails++;
      $display("FAIL %s: pri_pin=%0b stat_pin=%0b expected pri_pin=%0b stat_pin=%0b",
               tag, pri_pin, stat_pin, ep, es);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    check(tag);
    tick = 1'b0;
  endtask

  // run n cycles with a tick every div cycles
  task automatic run_ticks(input int n, input int div, input string tag);
    for (int i = 0; i < n; i++) begin
      tick = ((i % div) == div - 1);
      cyc(tag);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int tdiv, tc;
    // R1: reset
    pinv = 1'b1; dinv = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (pri_pin !== 1'b1 || stat_pin !== 1'b0) begin
      fails++;
      $display("FAIL R1: pri_pin=%0b stat_pin=%0b expected 1 0", pri_pin, stat_pin);
    end
    rst_n = 1'b1;
    repeat (4) cyc("R1");

    // R6/R7: three-wire, window 8, tick every 3 cycles
    tw = 1; win = 5'd8; pri = 1; txrx = 1; mst = 1; pinv = 0; dinv = 0;
    act = 1; cyc("R6");
    run_ticks(3 * 7, 3, "R7");     // seven ticks counted, still priority
    checks++;
    if (stat_pin !== 1'b1) begin
      fails++; $display("FAIL R7: stat_pin=%0b expected 1 after 7 ticks", stat_pin);
    end
    pri = 0; txrx = 0;             // R3: ignored mid-request
    run_ticks(3, 3, "R7");         // eighth tick -> direction
    run_ticks(6, 3, "R3");
    act = 0; cyc("R2");

    // R4/R5: four-wire, slave transmit reported as receive, inverted polarities
    tw = 0; pri = 1; txrx = 1; mst = 0; pinv = 1; dinv = 1;
    act = 1; run_ticks(5, 2, "R5");
    act = 0; cyc("R2");
    mst = 1; act = 1; run_ticks(5, 2, "R4");
    act = 0; cyc("R2");

    // R8: three-wire window zero
    tw = 1; win = 0; pinv = 0; dinv = 0; pri = 1; txrx = 1; mst = 1;
    act = 1; run_ticks(6, 1, "R8");
    act = 0; cyc("R2");

    // R10: drop mid-window, then full window again
    win = 5'd9; act = 1; cyc("R6");
    run_ticks(10, 2, "R10");
    act = 0; cyc("R10");
    act = 1; tick = 1; cyc("R9");   // tick on activation edge not counted
    run_ticks(2 * 9, 2, "R9");
    run_ticks(4, 2, "R9");
    act = 0; cyc("R10");

    // random phase
    void'($urandom(32'h5eed1234));
    tdiv = 1; tc = 0;
    for (int i = 0; i < 20000; i++) begin
      if (!act) begin
        if ($urandom_range(7) == 0) act = 1;
        tw = $urandom_range(1);
        case ($urandom_range(3))
          0: win = 0;
          default: win = 5'($urandom_range(20, 8));
        endcase
        pinv = $urandom_range(1); dinv = $urandom_range(1);
        tdiv = $urandom_range(6, 1);
      end else if ($urandom_range(39) == 0) act = 0;
      pri = $urandom_range(1); txrx = $urandom_range(1); mst = $urandom_range(1);
      tc++;
      if (tc >= tdiv) begin tick = 1; tc = 0; end
      if (m_phase == 0)      cyc("R2");
      else if (m_phase == 1) cyc("R6");
      else if (m_tw)         cyc("R5");
      else                   cyc("R4");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule